// File: doc/BRIEF.md
# External Memory Access Sequencer (Non-Multiplexed)

This block runs one read or write at a time on a separate-address, separate-data external memory bus for a single region. It accepts a request of address, write data and direction while idle. It then walks a fixed sequence of bus states and drives the chip select, the read and write strobes, the address, and the write data with its output enable. When the access ends it returns the read data and a one-cycle completion pulse.

The access shape is configured per request. A 2-state access uses only the two data cycles T1 and T2. A 3-state access adds 0 to 7 programmed wait cycles after T2, then pin-controlled wait cycles while the external wait input is high (if enabled), then a final data cycle T3. Either shape can be wrapped in one chip-select setup cycle before T1 and one chip-select hold cycle after the last data cycle. An early-negate option ends the read strobe one cycle before the last data cycle ends. All bus outputs come straight from flops.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, bus_cs_n, bus_rd_n and bus_wr_n are 1, and bus_doe and rsp_done are 0. A request raised during reset starts no access.
- R2: A request is accepted on a rising edge where the block is idle and req_valid is 1. The access occupies the following L cycles, with L = lead + 2 + (3-state ? pw + n + 1 : 0) + trail, where lead and trail are each 0 or 1. bus_cs_n is 0 in exactly those L consecutive cycles.
- R3: In 2-state mode (cfg_three_state = 0), cfg_pwait, cfg_wait_en and ext_wait have no effect, so L = lead + 2 + trail.
- R4: In 3-state mode, exactly cfg_pwait (0 to 7) programmed wait cycles lie between T2 and T3.
- R5: Pin waits apply only in 3-state mode with cfg_wait_en = 1. ext_wait is sampled at the end of the last cycle of T2 and the programmed waits, and again at the end of each pin-wait cycle. One further wait cycle is added each time it is sampled high. With cfg_wait_en = 0, ext_wait is ignored.
- R6: For a read, bus_rd_n is 0 from T1 through the last data cycle (T2 in 2-state, T3 in 3-state). With cfg_rd_early = 1 it is already 1 in the last data cycle. For a write it stays 1.
- R7: For a write, bus_wr_n is 0 from T2 through the last data cycle. For a read it stays 1. The two strobes are never 0 together.
- R8: For a write, bus_doe is 1 and bus_dout equals the request data from T1 through the last data cycle. bus_doe is 0 in the setup and hold cycles and during reads.
- R9: bus_addr equals the accepted request address in every cycle of the access.
- R10: rsp_done is 1 for exactly one cycle, the first cycle after the access. After a read, rsp_rdata holds the ext_rdata value sampled at the end of the last data cycle. A write leaves rsp_rdata unchanged.
- R11: Changes on req_valid, the request fields and all cfg_* inputs during an access do not alter that access. The configuration is captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present (sampled only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_three_state | input | 1 | 1 = 3-state access, 0 = 2-state |
| cfg_pwait | input | PWW | Programmed wait count (3-state only) |
| cfg_lead_ext | input | 1 | Insert chip-select setup cycle |
| cfg_trail_ext | input | 1 | Insert chip-select hold cycle |
| cfg_wait_en | input | 1 | Honour ext_wait (3-state only) |
| cfg_rd_early | input | 1 | Negate read strobe one cycle early |
| ext_wait | input | 1 | External wait request, active high |
| ext_rdata | input | DW | Read data from the bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Address bus |
| bus_dout | output | DW | Write data bus |
| bus_doe | output | 1 | Write data output enable |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | DW | Captured read data |

## Verification
The completion pulse of one access and the acceptance of the next request fall in the same idle cycle. The bench issues the next request at once after most accesses, and after a random gap of one or two idle cycles after the others. It judges that rsp_done and rsp_rdata are correct in that cycle, that chip select goes high for exactly that one cycle, and that the new access then has its full expected length. A second collision is between the programmed-wait count running out and ext_wait being high in that same sampling cycle. Random wait-pin hold lengths cover it against the bench's length formula.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_T1,
        PH_T2,
        PH_PWAIT,
        PH_XWAIT,
        PH_T3,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic three_state;
        logic lead_ext;
        logic trail_ext;
        logic wait_en;
        logic rd_early;
        logic write;
    } acc_cfg_t;

    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
        logic oe;
    } strobe_t;

endpackage

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == ONE);
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_pkg::*;
(
    input  phase_e   phase,
    input  acc_cfg_t cfg,
    output strobe_t  strb
);
    logic data_mid;
    logic last_data;

    always_comb begin
        data_mid  = (phase == PH_PWAIT) || (phase == PH_XWAIT)
                 || (phase == PH_T2 && cfg.three_state);
        last_data = (phase == PH_T3) || (phase == PH_T2 && !cfg.three_state);

        strb.cs = (phase != PH_IDLE);
        strb.rd = !cfg.write && ((phase == PH_T1) || data_mid
                                 || (last_data && !cfg.rd_early));
        strb.wr = cfg.write && (data_mid || last_data);
        strb.oe = cfg.write && ((phase == PH_T1) || data_mid || last_data);
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int PWW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           cfg_three_state,
    input  logic [PWW-1:0] cfg_pwait,
    input  logic           cfg_lead_ext,
    input  logic           cfg_trail_ext,
    input  logic           cfg_wait_en,
    input  logic           cfg_rd_early,
    input  logic           ext_wait,
    input  logic [DW-1:0]  ext_rdata,
    output logic           bus_cs_n,
    output logic           bus_rd_n,
    output logic           bus_wr_n,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_doe,
    output logic           rsp_done,
    output logic [DW-1:0]  rsp_rdata
);

    typedef struct packed {
        phase_e         phase;
        acc_cfg_t       cfg;
        logic [PWW-1:0] pw;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           done;
    } seq_t;

    seq_t    r_d, r_q;
    strobe_t strb_d, strb_q;
    logic    wait_load;
    logic    wait_last;
    logic    pin_hold;
    logic    last_data_q;

    xbus_wait_ctr #(.CW(PWW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (r_q.pw),
        .last     (wait_last)
    );

    always_comb begin
        pin_hold    = r_q.cfg.wait_en && ext_wait;
        last_data_q = (r_q.phase == PH_T3)
                   || (r_q.phase == PH_T2 && !r_q.cfg.three_state);
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        wait_load = 1'b0;

        if (last_data_q && !r_q.cfg.write) begin
            r_d.rdata = ext_rdata;
        end

        case (r_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.cfg.three_state = cfg_three_state;
                    r_d.cfg.lead_ext    = cfg_lead_ext;
                    r_d.cfg.trail_ext   = cfg_trail_ext;
                    r_d.cfg.wait_en     = cfg_wait_en;
                    r_d.cfg.rd_early    = cfg_rd_early;
                    r_d.cfg.write       = req_write;
                    r_d.pw              = cfg_pwait;
                    r_d.addr            = req_addr;
                    r_d.wdata           = req_wdata;
                    r_d.phase           = cfg_lead_ext ? PH_SETUP : PH_T1;
                end
            end
            PH_SETUP: r_d.phase = PH_T1;
            PH_T1:    r_d.phase = PH_T2;
            PH_T2: begin
                if (!r_q.cfg.three_state) begin
                    r_d.phase = r_q.cfg.trail_ext ? PH_HOLD : PH_IDLE;
                end else if (r_q.pw != '0) begin
                    r_d.phase = PH_PWAIT;
                    wait_load = 1'b1;
                end else begin
                    r_d.phase = pin_hold ? PH_XWAIT : PH_T3;
                end
            end
            PH_PWAIT: begin
                if (wait_last) begin
                    r_d.phase = pin_hold ? PH_XWAIT : PH_T3;
                end
            end
            PH_XWAIT: begin
                if (!ext_wait) begin
                    r_d.phase = PH_T3;
                end
            end
            PH_T3:    r_d.phase = r_q.cfg.trail_ext ? PH_HOLD : PH_IDLE;
            PH_HOLD:  r_d.phase = PH_IDLE;
            default:  r_d.phase = PH_IDLE;
        endcase

        if (r_q.phase != PH_IDLE && r_d.phase == PH_IDLE) begin
            r_d.done = 1'b1;
        end
    end

    xbus_strobe_dec u_dec (
        .phase (r_d.phase),
        .cfg   (r_d.cfg),
        .strb  (strb_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '{phase: PH_IDLE, default: '0};
            strb_q <= '0;
        end else begin
            r_q    <= r_d;
            strb_q <= strb_d;
        end
    end

    assign bus_cs_n  = !strb_q.cs;
    assign bus_rd_n  = !strb_q.rd;
    assign bus_wr_n  = !strb_q.wr;
    assign bus_doe   = strb_q.oe;
    assign bus_addr  = r_q.addr;
    assign bus_dout  = r_q.wdata;
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs_n,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          bus_doe,
    input logic          rsp_done,
    input logic [AW-1:0] bus_addr
);
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    p_doe_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_cs_n);

    p_wr_has_doe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_cs_n && !$past(bus_cs_n)));

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_doe  (bus_doe),
    .rsp_done (rsp_done),
    .bus_addr (bus_addr)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int PWW = 3;

    typedef struct {
        bit three, lead, trail, wen, early, write;
        int pw;
        int hold;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, ext_rdata = '0;
    logic cfg_three_state = 1'b0, cfg_lead_ext = 1'b0, cfg_trail_ext = 1'b0;
    logic cfg_wait_en = 1'b0, cfg_rd_early = 1'b0, ext_wait = 1'b0;
    logic [PWW-1:0] cfg_pwait = '0;
    logic bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, rsp_done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [DW-1:0] last_rd = '0;

    always #10 clk = ~clk;

    xbus_seq #(.AW(AW), .DW(DW), .PWW(PWW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_three_state(cfg_three_state), .cfg_pwait(cfg_pwait),
        .cfg_lead_ext(cfg_lead_ext), .cfg_trail_ext(cfg_trail_ext),
        .cfg_wait_en(cfg_wait_en), .cfg_rd_early(cfg_rd_early),
        .ext_wait(ext_wait), .ext_rdata(ext_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pin_waits(acc_t a);
        int d;
        d = a.lead + 1 + a.pw;
        if (!a.three || !a.wen || a.hold <= d) return 0;
        return a.hold - d;
    endfunction

    function automatic int last_data(acc_t a);
        if (!a.three) return a.lead + 1;
        return a.lead + 2 + a.pw + pin_waits(a);
    endfunction

    function automatic int acc_len(acc_t a);
        return last_data(a) + 1 + a.trail;
    endfunction

    task automatic drive_req(acc_t a);
        req_valid       = 1'b1;
        req_write       = a.write;
        req_addr        = a.addr;
        req_wdata       = a.wdata;
        cfg_three_state = a.three;
        cfg_pwait       = PWW'(a.pw);
        cfg_lead_ext    = a.lead;
        cfg_trail_ext   = a.trail;
        cfg_wait_en     = a.wen;
        cfg_rd_early    = a.early;
        ext_rdata       = a.rdata;
        ext_wait        = 1'b0;
    endtask

    task automatic scramble();
        req_valid       = 1'($urandom);
        req_write       = 1'($urandom);
        req_addr        = AW'($urandom);
        req_wdata       = DW'($urandom);
        cfg_three_state = 1'($urandom);
        cfg_pwait       = PWW'($urandom);
        cfg_lead_ext    = 1'($urandom);
        cfg_trail_ext   = 1'($urandom);
        cfg_wait_en     = 1'($urandom);
        cfg_rd_early    = 1'($urandom);
    endtask

    // Request already on the inputs; the next rising edge accepts it.
    task automatic run(acc_t a);
        int ld, len, t1, t2;
        logic exp_rd, exp_wr, exp_oe;
        ld  = last_data(a);
        len = acc_len(a);
        t1  = a.lead;
        t2  = a.lead + 1;
        @(posedge clk);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            exp_rd = !(!a.write && k >= t1 && k <= ld - (a.early ? 1 : 0));
            exp_wr = !(a.write && k >= t2 && k <= ld);
            exp_oe = a.write && k >= t1 && k <= ld;
            chk(bus_cs_n == 1'b0, "R2 cs_n low in access", bus_cs_n, 0);
            chk(bus_rd_n == exp_rd, "R6 rd_n", bus_rd_n, exp_rd);
            chk(bus_wr_n == exp_wr, "R7 wr_n", bus_wr_n, exp_wr);
            chk(bus_doe == exp_oe, "R8 doe", bus_doe, exp_oe);
            if (exp_oe) chk(bus_dout == a.wdata, "R8 dout", bus_dout, a.wdata);
            chk(bus_addr == a.addr, "R9 addr", bus_addr, a.addr);
            chk(rsp_done == 1'b0, "R10 done early", rsp_done, 0);
            if (k < len - 1) scramble(); // R11 noise on request and cfg
            else req_valid = 1'b0;
            ext_wait = (k < a.hold);
        end
        @(negedge clk);
        ext_wait = 1'b0;
        if (!a.write) last_rd = a.rdata;
        chk(bus_cs_n == 1'b1, "R2 cs_n high after L cycles", bus_cs_n, 1);
        chk(rsp_done == 1'b1, "R10 done pulse", rsp_done, 1);
        chk(rsp_rdata == last_rd, "R10 rdata", rsp_rdata, last_rd);
    endtask

    function automatic acc_t mk(bit three, bit lead, bit trail, bit wen, bit early,
                                bit write, int pw, int hold);
        acc_t a;
        a.three = three; a.lead = lead; a.trail = trail; a.wen = wen;
        a.early = early; a.write = write; a.pw = pw; a.hold = hold;
        a.addr = AW'($urandom); a.wdata = DW'($urandom); a.rdata = DW'($urandom);
        return a;
    endfunction

    task automatic idle_gap(int g);
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            chk(bus_cs_n == 1'b1 && rsp_done == 1'b0, "R10 idle gap", {bus_cs_n, rsp_done}, 2'b10);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        acc_t a;
        void'($urandom(32'd4242));
        // R1: request during reset starts nothing
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe && !rsp_done,
            "R1 reset outputs", {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, rsp_done}, 5'b11100);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe && !rsp_done,
            "R1 idle after reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, rsp_done}, 5'b11100);

        // Directed corners
        a = mk(0, 0, 0, 0, 0, 0, 0, 0); drive_req(a); run(a);     // R2 minimal read
        a = mk(0, 1, 1, 1, 0, 1, 7, 9); drive_req(a); run(a);     // R3 2-state ignores waits
        a = mk(0, 0, 0, 0, 1, 0, 0, 0); drive_req(a); run(a);     // R6 early in 2-state
        a = mk(1, 1, 1, 0, 0, 0, 7, 0); drive_req(a); run(a);     // R4 pw=7 with extensions
        a = mk(1, 0, 0, 0, 0, 1, 3, 10); drive_req(a); run(a);    // R5 pin ignored when disabled
        a = mk(1, 0, 0, 1, 0, 0, 0, 2); drive_req(a); run(a);     // R5 pin wait after T2
        a = mk(1, 0, 1, 1, 1, 1, 2, 8); drive_req(a); run(a);     // R5 pin after pw
        a = mk(1, 1, 0, 1, 1, 0, 1, 3); drive_req(a); run(a);     // R5 pin exactly at count end
        idle_gap(2);

        for (int i = 0; i < 400; i++) begin
            a = mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                   int'($urandom_range(0, 14)));
            drive_req(a);
            run(a);
            if ($urandom_range(0, 3) == 0) begin
                req_valid = 1'b0;
                idle_gap(int'($urandom_range(1, 2)));
            end
        end
        req_valid = 1'b0;
        idle_gap(1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule